// File: doc/BRIEF.md
# Two-Stream Double-Rate Interleaver

The block joins two word streams into one stream at twice their rate. Each input stream holds one word for a whole slow-clock period. The output produces one word on every fast-clock cycle. The block runs only on the fast clock, whose rising edges line up with the slow clock's and which has exactly twice its frequency.

A one-cycle `sync_i` pulse tells the block which fast edge coincides with a slow rising edge. From that edge on, an internal phase bit toggles on every fast edge. Both input words are copied into fast-domain registers only on the edge halfway through the slow period, never on an edge where the slow source may be changing. A registered multiplexer then sends out the first-stream word of that pair and then the second-stream word.

When both clocks run at the same rate, a runtime bypass mode forwards only the first link, one word per clock, with no interleaving.

Top module: `ilv_top`

## Requirements
- R1: While `rst_n_i` is low (synchronous, sampled on the fast edge), `valid_o` is 0 and `dout_o` is 0.
- R2: A high `sync_i` on an edge marks that edge as a slow rising edge. Until the first such edge after reset, nothing is captured and `valid_o` stays 0 in interleave mode.
- R3: Inputs `a_i`/`b_i` are captured only on the edge right after a sync edge and on every second edge after that, never on a slow rising edge.
- R4: In interleave mode (`bypass_i`=0), the edge after a capture drives `dout_o` with the captured `a_i` word. The next edge drives the captured `b_i` word of the same pair.
- R5: `valid_o` rises on the edge after the first capture and then stays 1 while the stream stays aligned.
- R6: A sync on an edge that the phase treated as a capture edge re-aligns the phase and discards the pending pair. `valid_o` is 0 on that edge and on the next one, then resumes with the new pair in R4 order.
- R7: With `bypass_i`=1, every edge out of reset loads `dout_o` with `a_i` and sets `valid_o`=1. `b_i` has no effect on the output.
- R8: A sync that falls on an edge already treated as a slow rising edge leaves the output sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast clock, twice the slow rate and edge aligned |
| rst_n_i | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Pulse marking a fast edge that coincides with a slow rising edge |
| bypass_i | input | 1 | 1: both clocks equal, pass the first link through |
| a_i | input | DATA_W | First-stream word, updated once per slow period |
| b_i | input | DATA_W | Second-stream word, updated once per slow period |
| dout_o | output | DATA_W | Interleaved or bypassed output word |
| valid_o | output | 1 | `dout_o` carries a real word |

## Verification
Both streams carry distinct counting patterns with different offsets. Any swap of the first and second word, reuse of a word from an earlier pair, or capture on the wrong edge therefore shows up as a value mismatch against the reference queue.

The bench places sync pulses in three ways:
- before any capture, which shows the lock-in;
- on a slow edge, which must change nothing;
- on a capture edge, which must flush the pending pair.

Bypass runs use a per-cycle count on the first link and random words on the second. This shows that only the first link reaches the output, without a one-cycle lag.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef struct packed {
        logic mid;     // next edge is the mid-period capture edge
        logic locked;  // a sync has been seen since reset
    } phase_st_t;

endpackage

// File: rtl/ilv_phase.sv
module ilv_phase
    import ilv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sync_i,
    output logic cap_en_o,
    output logic sel_b_o,
    output logic flush_o
);

    phase_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.mid    = 1'b1;
            st_d.locked = 1'b1;
        end else if (st_q.locked) begin
            st_d.mid = ~st_q.mid;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign cap_en_o = st_q.locked & st_q.mid & ~sync_i;
    assign sel_b_o  = st_q.mid;
    assign flush_o  = st_q.locked & st_q.mid & sync_i;

    // R3
    phase_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (st_q.locked && !sync_i) |=> (st_q.mid != $past(st_q.mid)));

    // R2
    sync_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        sync_i |=> (st_q.mid && st_q.locked));

endmodule

// File: rtl/ilv_capture.sv
module ilv_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              cap_en_i,
    input  logic              flush_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o,
    output logic              pair_vld_o
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              vld;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.vld = 1'b0;
        end else if (cap_en_i) begin
            st_d.a   = a_i;
            st_d.b   = b_i;
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign a_o        = st_q.a;
    assign b_o        = st_q.b;
    assign pair_vld_o = st_q.vld;

    // R3
    hold_off_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !cap_en_i |=> ($stable(a_o) && $stable(b_o)));

    // R6
    flush_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        flush_i |=> !pair_vld_o);

endmodule

// File: rtl/ilv_outmux.sv
module ilv_outmux #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              bypass_i,
    input  logic              sel_b_i,
    input  logic              flush_i,
    input  logic              pair_vld_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] byp_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              valid_o
);

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              vld;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bypass_i) begin
            st_d.dout = byp_i;
            st_d.vld  = 1'b1;
        end else begin
            st_d.dout = sel_b_i ? b_i : a_i;
            st_d.vld  = pair_vld_i & ~flush_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    assign dout_o  = st_q.dout;
    assign valid_o = st_q.vld;

    // R7
    bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        bypass_i |=> (valid_o && dout_o == $past(byp_i)));

    // R4
    first_word_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!bypass_i && !sel_b_i) |=> (dout_o == $past(a_i)));

    // R5
    valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!bypass_i && pair_vld_i && !flush_i) |=> valid_o);

    // R6
    flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!bypass_i && flush_i) |=> !valid_o);

endmodule

// File: rtl/ilv_top.sv
module ilv_top #(
    parameter int DATA_W = 16
) (
    input  logic              clk_fast_i,
    input  logic              rst_n_i,
    input  logic              sync_i,
    input  logic              bypass_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              valid_o
);

    logic              cap_en;
    logic              sel_b;
    logic              flush;
    logic              pair_vld;
    logic [DATA_W-1:0] a_cap;
    logic [DATA_W-1:0] b_cap;

    ilv_phase u_phase (
        .clk_i    (clk_fast_i),
        .rst_n_i  (rst_n_i),
        .sync_i   (sync_i),
        .cap_en_o (cap_en),
        .sel_b_o  (sel_b),
        .flush_o  (flush)
    );

    ilv_capture #(.DATA_W(DATA_W)) u_capture (
        .clk_i      (clk_fast_i),
        .rst_n_i    (rst_n_i),
        .cap_en_i   (cap_en),
        .flush_i    (flush),
        .a_i        (a_i),
        .b_i        (b_i),
        .a_o        (a_cap),
        .b_o        (b_cap),
        .pair_vld_o (pair_vld)
    );

    ilv_outmux #(.DATA_W(DATA_W)) u_outmux (
        .clk_i      (clk_fast_i),
        .rst_n_i    (rst_n_i),
        .bypass_i   (bypass_i),
        .sel_b_i    (sel_b),
        .flush_i    (flush),
        .pair_vld_i (pair_vld),
        .a_i        (a_cap),
        .b_i        (b_cap),
        .byp_i      (a_i),
        .dout_o     (dout_o),
        .valid_o    (valid_o)
    );

endmodule

// File: tb/ilv_top_tb_top.sv
`timescale 1ns/1ps
module ilv_top_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync = 1'b0;
    logic         byp = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] dout;
    logic         valid;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference model state
    bit           m_locked = 1'b0;
    bit           m_mid    = 1'b0;
    bit           ev       = 1'b0;
    logic [W-1:0] ed       = '0;
    logic [W-1:0] q[$];
    int           pat      = 0;

    always #2 clk = ~clk;   // 250 MHz

    ilv_top #(.DATA_W(W)) dut_i (
        .clk_fast_i (clk),
        .rst_n_i    (rst_n),
        .sync_i     (sync),
        .bypass_i   (byp),
        .a_i        (a),
        .b_i        (b),
        .dout_o     (dout),
        .valid_o    (valid)
    );

    task automatic model_edge();
        if (!rst_n) begin
            m_locked = 0; m_mid = 0; ev = 0; ed = '0; q.delete();
        end else begin
            if (byp) begin
                ev = 1; ed = a;
            end else if (q.size() > 0) begin
                ed = q.pop_front(); ev = 1;
            end else begin
                ev = 0;
            end
            if (sync) begin
                if (m_locked && m_mid) begin
                    q.delete();
                    if (!byp) ev = 0;
                end
                m_locked = 1; m_mid = 1;
            end else if (m_locked) begin
                if (m_mid) begin
                    q.push_back(a);
                    q.push_back(b);
                end
                m_mid = !m_mid;
            end
        end
    endtask

    task automatic compare(input string tag);
        vectors++;
        if (valid !== ev) begin
            errors++;
            $display("FAIL %s valid actual=%0b expected=%0b", tag, valid, ev);
        end else if (ev && dout !== ed) begin
            errors++;
            $display("FAIL %s dout actual=%h expected=%h", tag, dout, ed);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        sync = 1'b0;
        if (byp) begin
            pat++;
            a = W'(16'h3000 + pat);
            b = W'($urandom);
        end else if (m_mid) begin
            // the edge just taken was a slow rising edge: slow sources update
            pat++;
            a = W'(16'h1000 + pat);
            b = W'(16'h2000 + pat);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) cyc("R1");
        vectors++;
        if (valid !== 1'b0 || dout !== '0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b/%h expected=0/0", valid, dout);
        end
        rst_n = 1'b1;
        // R2: no lock without sync
        repeat (4) cyc("R2");
        sync = 1'b1;
        cyc("R2");
        // R3 R4 R5: interleave with counting streams
        repeat (40) cyc("R4");
        // R8: aligned sync (next edge is a slow edge)
        if (m_mid) cyc("R5");
        sync = 1'b1;
        cyc("R8");
        repeat (12) cyc("R8");
        // R6: misaligned sync (next edge would be a capture edge)
        if (!m_mid) cyc("R5");
        sync = 1'b1;
        cyc("R6");
        repeat (20) cyc("R6");
        // R3: capture timing continues after re-alignment
        repeat (10) cyc("R3");
        // R7: bypass mode from a fresh reset
        rst_n = 1'b0;
        byp   = 1'b1;
        repeat (2) cyc("R1");
        rst_n = 1'b1;
        repeat (30) cyc("R7");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule